// File: doc/BRIEF.md
# Chainable Dynamic Shift-Left Unit

This execution unit carries out a 64-bit left shift whose vacated low bits are filled from a third operand instead of zeros. It takes a 32-bit instruction word in a four-register layout together with three 64-bit operands: the value to shift, the word whose low six bits give the shift distance, and the fill word. It returns the shifted result and a carry-out word holding the bits pushed off the top. It also returns an overflow flag and a 4-bit condition field with its own write enable.

The shift is built as a left rotation followed by a mask. The carry-out word comes back right-aligned, so it can be fed straight in as the fill operand of the next instance. A multi-word left shift is therefore a chain of these operations, starting from the least significant word.

An output register stage is selected by a parameter. When it is on (the default), every output appears one clock after its inputs, and a synchronous active-high reset clears the registers.

Top module: `chain_shl_unit`

## Requirements
- R1: `dst_idx` carries the destination register field of the instruction, which is `instr[25:21]` (LSB-0 numbering).
- R2: `out_valid` is high only when `in_valid` is high, the primary opcode `instr[31:26]` equals 4, and the extended opcode `instr[5:1]` equals the parameter `XO_SEL`.
- R3: The shift distance n is `op_b[5:0]` (0 to 63). Bits 63:6 of `op_b` have no effect on any output.
- R4: `res_rt` equals `(op_a << n) | (op_c & ((1 << n) - 1))`, so the low n bits come from `op_c`. With n = 0 it equals `op_a`.
- R5: `res_rs` equals `op_a >> (64 - n)` for n > 0, and 0 for n = 0. It holds the bits shifted out, right-aligned, with zeros above bit n-1.
- R6: `ovf` is 1 exactly when `res_rs` is nonzero.
- R7: The condition field has these bits: `cr0[3]` is set when `res_rt` is negative as a signed value, `cr0[2]` when it is positive and nonzero, and `cr0[1]` when it is zero. `cr0[0]` copies `so_in`.
- R8: `cr0_we` equals the record bit `instr[0]` ANDed with `out_valid`.
- R9: With `REG_OUT` = 1, every output is due one clock after its inputs, and a reset cycle drives every output to zero.
- R10: Two chained operations perform a 128-bit left shift. The first uses the low word with fill 0, and the second uses the high word with the first operation's `res_rs` as fill. The two `res_rt` values equal the two halves of `{high, low} << n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| op_a | input | 64 | Value to shift |
| op_b | input | 64 | Shift distance source, low 6 bits used |
| op_c | input | 64 | Fill word for vacated low bits |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Instruction accepted |
| dst_idx | output | 5 | Destination register index |
| res_rt | output | 64 | Shifted and filled result |
| res_rs | output | 64 | Bits shifted out, right-aligned |
| ovf | output | 1 | Carry-out word is nonzero |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |
| cr0_we | output | 1 | Condition field write enable |

## Verification
With the register stage on, every result (`res_rt`, `res_rs`, `ovf`, `cr0`, `cr0_we`, `out_valid` and `dst_idx`) is due one clock after the operands are applied. The bench drives each operand set on a falling edge and lets one rising edge capture it. It reads all outputs on the following falling edge, before the next set is driven. A chained shift takes two such steps, and the carry word read back from the first step is driven as the fill of the second. The bound checker keeps its own one-stage copy of the inputs, so its properties compare each output against the inputs that produced it.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    localparam int          XLEN     = 64;
    localparam int          SHW      = $clog2(XLEN);
    localparam int          CRW      = 4;
    localparam logic [5:0]  PRIM_OP  = 6'd4;

    // Instruction layout, most significant field first.
    typedef struct packed {
        logic [5:0] po;
        logic [4:0] dst;
        logic [4:0] src_a;
        logic [4:0] src_b;
        logic [4:0] src_c;
        logic [4:0] xo;
        logic       rec;
    } insn_t;

    typedef struct packed {
        logic            vld;
        logic [4:0]      dst;
        logic [XLEN-1:0] rt;
        logic [XLEN-1:0] rs;
        logic            ovf;
        logic [CRW-1:0]  cr;
        logic            cr_we;
    } res_t;

    function automatic logic [XLEN-1:0] rotl(input logic [XLEN-1:0] v, input logic [SHW-1:0] n);
        logic [2*XLEN-1:0] t;
        t = {v, v} << n;
        return t[2*XLEN-1:XLEN];
    endfunction

    function automatic logic [XLEN-1:0] low_ones(input logic [SHW-1:0] n);
        return (XLEN'(1) << n) - XLEN'(1);
    endfunction
endpackage

// File: rtl/dsl_decode.sv
module dsl_decode
    import dsl_pkg::*;
#(
    parameter logic [4:0] XO_SEL = 5'd27
) (
    input  logic        in_valid,
    input  logic [31:0] instr,
    output insn_t       fields,
    output logic        accept
);
    always_comb begin
        fields = insn_t'(instr);
        accept = in_valid && (fields.po == PRIM_OP) && (fields.xo == XO_SEL);
    end
endmodule

// File: rtl/dsl_rotmask.sv
module dsl_rotmask
    import dsl_pkg::*;
(
    input  logic [XLEN-1:0] val,
    input  logic [XLEN-1:0] amt,
    input  logic [XLEN-1:0] fill,
    output logic [XLEN-1:0] rt,
    output logic [XLEN-1:0] rs
);
    logic [SHW-1:0]  n;
    logic [XLEN-1:0] rot;
    logic [XLEN-1:0] keep;

    always_comb begin
        n    = amt[SHW-1:0];
        rot  = rotl(val, n);
        keep = ~low_ones(n);
        rt   = (rot & keep) | (fill & ~keep);
        rs   = rot & ~keep;
    end
endmodule

// File: rtl/dsl_flags.sv
module dsl_flags
    import dsl_pkg::*;
(
    input  logic [XLEN-1:0] rt,
    input  logic [XLEN-1:0] rs,
    input  logic            so_in,
    input  logic            rec,
    input  logic            accept,
    output logic            ovf,
    output logic [CRW-1:0]  cr,
    output logic            cr_we
);
    logic neg, zero;

    always_comb begin
        ovf   = |rs;
        neg   = rt[XLEN-1];
        zero  = ~|rt;
        cr    = {neg, ~neg & ~zero, zero, so_in};
        cr_we = rec & accept;
    end
endmodule

// File: rtl/chain_shl_unit.sv
module chain_shl_unit
    import dsl_pkg::*;
#(
    parameter logic [4:0] XO_SEL  = 5'd27,
    parameter bit         REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic [63:0] op_c,
    input  logic        so_in,
    output logic        out_valid,
    output logic [4:0]  dst_idx,
    output logic [63:0] res_rt,
    output logic [63:0] res_rs,
    output logic        ovf,
    output logic [3:0]  cr0,
    output logic        cr0_we
);
    insn_t           fld;
    logic            acc;
    logic [XLEN-1:0] rt_c, rs_c;
    logic            ovf_c, we_c;
    logic [CRW-1:0]  cr_c;
    res_t            nxt, cur;

    dsl_decode #(.XO_SEL(XO_SEL)) u_dec (
        .in_valid (in_valid),
        .instr    (instr),
        .fields   (fld),
        .accept   (acc)
    );

    dsl_rotmask u_dp (
        .val  (op_a),
        .amt  (op_b),
        .fill (op_c),
        .rt   (rt_c),
        .rs   (rs_c)
    );

    dsl_flags u_fl (
        .rt     (rt_c),
        .rs     (rs_c),
        .so_in  (so_in),
        .rec    (fld.rec),
        .accept (acc),
        .ovf    (ovf_c),
        .cr     (cr_c),
        .cr_we  (we_c)
    );

    always_comb begin
        nxt.vld   = acc;
        nxt.dst   = fld.dst;
        nxt.rt    = rt_c;
        nxt.rs    = rs_c;
        nxt.ovf   = ovf_c;
        nxt.cr    = cr_c;
        nxt.cr_we = we_c;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) cur <= '0;
                else     cur <= nxt;
            end
        end else begin : g_comb
            always_comb cur = nxt;
        end
    endgenerate

    assign out_valid = cur.vld;
    assign dst_idx   = cur.dst;
    assign res_rt    = cur.rt;
    assign res_rs    = cur.rs;
    assign ovf       = cur.ovf;
    assign cr0       = cur.cr;
    assign cr0_we    = cur.cr_we;
endmodule

// File: rtl/dsl_chk.sv
module dsl_chk
    import dsl_pkg::*;
#(
    parameter logic [4:0] XO_SEL  = 5'd27,
    parameter bit         REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [63:0] op_b,
    input logic [63:0] op_c,
    input logic        out_valid,
    input logic [63:0] res_rt,
    input logic [63:0] res_rs,
    input logic        ovf,
    input logic [3:0]  cr0,
    input logic        cr0_we
);
    logic        now_acc;
    logic        q_acc, q_rec;
    logic [5:0]  q_n;
    logic [63:0] q_c;

    assign now_acc = in_valid && (instr[31:26] == 6'd4) && (instr[5:1] == XO_SEL);

    generate
        if (REG_OUT) begin : g_d
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_acc <= 1'b0; q_rec <= 1'b0; q_n <= '0; q_c <= '0;
                end else begin
                    q_acc <= now_acc; q_rec <= instr[0]; q_n <= op_b[5:0]; q_c <= op_c;
                end
            end
        end else begin : g_c
            always_comb begin
                q_acc = now_acc; q_rec = instr[0]; q_n = op_b[5:0]; q_c = op_c;
            end
        end
    endgenerate

    AST_ACCEPT:  assert property (@(posedge clk) disable iff (rst) out_valid == q_acc);                              // R2
    AST_FILL:    assert property (@(posedge clk) disable iff (rst) ((res_rt ^ q_c) & low_ones(q_n)) == '0);          // R4
    AST_RS_HIGH: assert property (@(posedge clk) disable iff (rst) (res_rs & ~low_ones(q_n)) == '0);                 // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (res_rs == '0) |-> !ovf);                      // R6
    AST_OVERFLOW:    assert property (@(posedge clk) disable iff (rst) (res_rs != '0) |-> ovf);                       // R6
    AST_CR_ONE:  assert property (@(posedge clk) disable iff (rst) out_valid |-> ($countones(cr0[3:1]) == 1));       // R7
    AST_CR_WE:   assert property (@(posedge clk) disable iff (rst) cr0_we == (q_acc && q_rec));                      // R8
endmodule

bind chain_shl_unit dsl_chk #(.XO_SEL(XO_SEL), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .op_b      (op_b),
    .op_c      (op_c),
    .out_valid (out_valid),
    .res_rt    (res_rt),
    .res_rs    (res_rs),
    .ovf       (ovf),
    .cr0       (cr0),
    .cr0_we    (cr0_we)
);

// File: tb/sim_chain_shl_unit.sv
`timescale 1ns/1ps
module sim_chain_shl_unit;
    localparam logic [4:0] XO = 5'd27;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] op_a = '0, op_b = '0, op_c = '0;
    logic        so_in = 1'b0;
    logic        out_valid, ovf, cr0_we;
    logic [4:0]  dst_idx;
    logic [63:0] res_rt, res_rs;
    logic [3:0]  cr0;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    chain_shl_unit #(.XO_SEL(XO), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .so_in(so_in),
        .out_valid(out_valid), .dst_idx(dst_idx), .res_rt(res_rt), .res_rs(res_rs),
        .ovf(ovf), .cr0(cr0), .cr0_we(cr0_we)
    );

    function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rt,
                                       input logic [4:0] xo, input logic rc);
        return {po, rt, 5'd1, 5'd2, 5'd3, xo, rc};
    endfunction

    function automatic logic [63:0] exp_rt(input logic [63:0] a, input logic [63:0] c, input int n);
        return (a << n) | (c & ((64'd1 << n) - 64'd1));
    endfunction

    function automatic logic [63:0] exp_rs(input logic [63:0] a, input int n);
        return (n == 0) ? 64'd0 : (a >> (64 - n));
    endfunction

    function automatic logic [3:0] exp_cr(input logic [63:0] r, input logic so);
        return {r[63], !r[63] && (r != 0), r == 0, so};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive on a falling edge, capture on the rising edge, read on the next falling edge
    task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] c, input logic so);
        in_valid = v; instr = ins; op_a = a; op_b = b; op_c = c; so_in = so;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic full(input string tag, input logic [31:0] ins, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] c, input logic so);
        int n;
        logic [63:0] rt;
        n  = int'(b[5:0]);
        rt = exp_rt(a, c, n);
        step(1'b1, ins, a, b, c, so);
        chk({tag, " R2 valid"}, 64'(out_valid), 64'd1);
        chk({tag, " R1 dst"}, 64'(dst_idx), 64'(ins[25:21]));
        chk({tag, " R4 rt"}, res_rt, rt);
        chk({tag, " R5 rs"}, res_rs, exp_rs(a, n));
        chk({tag, " R6 ovf"}, 64'(ovf), 64'(exp_rs(a, n) != 0));
        chk({tag, " R7 cr0"}, 64'(cr0), 64'(exp_cr(rt, so)));
        chk({tag, " R8 we"}, 64'(cr0_we), 64'(ins[0]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] lo, hi, rs_lo, rt_lo;
        logic [127:0] wide;
        int seed;
        seed = 7;
        void'($urandom(seed));

        in_valid = 1'b1; instr = mk(6'd4, 5'd9, XO, 1'b1);
        op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'd5; op_c = '1; so_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 reset valid", 64'(out_valid), 64'd0);
        chk("R9 reset rt", res_rt, 64'd0);
        chk("R9 reset rs", res_rs, 64'd0);
        chk("R9 reset cr0", 64'({cr0, cr0_we, ovf}), 64'd0);
        rst = 1'b0;

        // n = 0: plain copy, no carry
        full("n0", mk(6'd4, 5'd3, XO, 1'b1), 64'h8000_0000_0000_0001, 64'd0, '1, 1'b0);
        // n = 63
        full("n63", mk(6'd4, 5'd31, XO, 1'b0), 64'hDEAD_BEEF_0123_4567, 64'd63, 64'h5555_5555_5555_5555, 1'b1);
        // zero result
        full("zero", mk(6'd4, 5'd0, XO, 1'b1), 64'd0, 64'd17, 64'd0, 1'b0);
        // R3: high bits of op_b ignored, same result as plain distance
        full("R3 hi b", mk(6'd4, 5'd7, XO, 1'b1), 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFC4, 64'h0F0F, 1'b0);
        chk("R3 n=4 rt", res_rt, exp_rt(64'h0123_4567_89AB_CDEF, 64'h0F0F, 4));

        // R2: rejects wrong primary, wrong extended, and no valid
        step(1'b1, mk(6'd5, 5'd1, XO, 1'b1), 64'd1, 64'd1, 64'd0, 1'b0);
        chk("R2 bad primary", 64'({out_valid, cr0_we}), 64'd0);
        step(1'b1, mk(6'd4, 5'd1, XO ^ 5'd1, 1'b1), 64'd1, 64'd1, 64'd0, 1'b0);
        chk("R2 bad xo", 64'({out_valid, cr0_we}), 64'd0);
        step(1'b0, mk(6'd4, 5'd1, XO, 1'b1), 64'd1, 64'd1, 64'd0, 1'b0);
        chk("R2 no valid", 64'({out_valid, cr0_we}), 64'd0);

        // random sweep
        for (int i = 0; i < 300; i++) begin
            full("rand", mk(6'd4, 5'($urandom), XO, 1'($urandom)),
                 {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end

        // R10: two-word chained shift
        for (int k = 0; k < 8; k++) begin
            int n;
            n  = (k == 0) ? 63 : ((k == 1) ? 0 : int'($urandom % 64));
            lo = {$urandom, $urandom};
            hi = {$urandom, $urandom};
            wide = {hi, lo} << n;
            step(1'b1, mk(6'd4, 5'd2, XO, 1'b0), lo, 64'(n), 64'd0, 1'b0);
            rt_lo = res_rt; rs_lo = res_rs;
            step(1'b1, mk(6'd4, 5'd3, XO, 1'b0), hi, 64'(n), rs_lo, 1'b0);
            chk("R10 chain low", rt_lo, wide[63:0]);
            chk("R10 chain high", res_rt, wide[127:64]);
        end

        // R9: reset mid-stream clears outputs
        in_valid = 1'b1; instr = mk(6'd4, 5'd4, XO, 1'b1); op_a = '1; op_b = 64'd8; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 mid reset", 64'({out_valid, ovf, cr0_we}), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule